// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block is a watchdog timer that a processor core reaches over a byte-wide register bus. Its counter runs from the system clock or from a slow clock enable. If software does not restart it in time, it overflows and asks the chip for an internal reset. There are two registers. The setup register picks the counter clock, picks the overflow period, and can stop the watchdog. The restart register clears the counter, but only when it receives one key byte. The setup register takes one write after each reset. Any misuse of the bus counts as a protocol violation and raises the same reset request as an overflow: a wrong key, a single-bit read-modify-write access to the restart register, or a repeated setup write.

A four-state machine controls the block:
- `ST_OPEN`: running, setup register still writable.
- `ST_LOCK`: running, setup register spent.
- `ST_STOP`: watchdog halted by the setup write.
- `ST_FIRE`: the one-cycle reset request.

The transitions are:
- open-to-lock: the setup write has the stop bit clear.
- open-to-stop: the setup write has the stop bit set.
- open-to-fire and lock-to-fire: a violation or an overflow.
- fire-to-open: taken on the next clock, and it restores every register to its reset value.
- stop: left only by the external reset.

Top module: `kwdt_top`

## Requirements
- R1: After reset, `rst_req` is 0, a read of the restart register (0xFF49) returns 0x9A, and a read of the setup register (0xFF48) returns 0x07 (system clock, period select 7, running).
- R2: Every read of the restart register returns 0x9A, whatever was last written to it.
- R3: A byte write of 0xAC to the restart register clears the counter, and counting starts again from zero. With period select N, `rst_req` rises 2^(N+11) counter ticks after the write edge. A restart before that point prevents the overflow.
- R4: In `ST_OPEN` or `ST_LOCK`, a byte write to the restart register with any value other than 0xAC raises `rst_req` after that edge.
- R5: In `ST_OPEN` or `ST_LOCK`, any access with `bus_bitop`=1 to the restart register, read or write and whatever its data, raises `rst_req`.
- R6: The first byte write to the setup register after reset is accepted and clears the counter. In `ST_LOCK`, a further byte write to it raises `rst_req`.
- R7: A write to the setup register with `bus_bitop`=1 is ignored. The register keeps its value, the one permitted write is not used up, and no reset is requested.
- R8: The setup register fields are bits [2:0] for the period select N, bit 3 for the counter clock (0 = every clock, 1 = only on `lsclk_en`), and bit 4 for stop. An accepted write with bit 4 set stops the counter. While stopped, a wrong key, a single-bit access, or another setup write never raises `rst_req`.
- R9: Counter overflow while the watchdog is running raises `rst_req`.
- R10: `rst_req` stays high for exactly one cycle. On the next edge, all state returns to reset values, including the setup register and its write-once flag.
- R11: With bit 3 of the setup register set, the counter advances only in cycles where `lsclk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_bitop | input | 1 | Marks the access as a single-bit read-modify-write |
| bus_wdata | input | 8 | Write data |
| lsclk_en | input | 1 | Slow-clock tick enable |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| rst_req | output | 1 | Internal reset request, one cycle |

## Verification
A wrong state register changes `rst_req` within one edge of the next bus access that the states treat differently. For example, a stuck write-once flag shows up on the second setup write, and a stop state that still checks violations shows up on the first bad key. A wrong counter width, limit or clock choice shows as `rst_req` rising at a cycle other than 2^(N+11) ticks after a restart, so it is caught at the overflow cycle itself. A setup register that is not restored after a fire shows on the very next setup read.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam logic [7:0] RESTART_KEY  = 8'hAC;
    localparam logic [7:0] EN_READ_VAL  = 8'h9A;
    localparam logic [7:0] MODE_RST_VAL = 8'h07;

    localparam int SRC_BIT  = 3;
    localparam int STOP_BIT = 4;

    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_LOCK = 2'd1,
        ST_STOP = 2'd2,
        ST_FIRE = 2'd3
    } kwdt_state_e;

    typedef struct packed {
        logic key_ok;
        logic key_bad;
        logic en_bitop;
        logic mode_wr;
    } kwdt_evt_t;

endpackage

// File: rtl/kwdt_busdec.sv
module kwdt_busdec
    import kwdt_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFF48,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFF49
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              bitop,
    input  logic [7:0]        wdata,
    input  logic [7:0]        mode_q,
    output kwdt_evt_t         evt,
    output logic [7:0]        rdata
);

    logic hit_en;
    logic hit_mode;
    logic byte_wr;

    assign hit_en   = (addr == EN_ADDR);
    assign hit_mode = (addr == MODE_ADDR);
    assign byte_wr  = wr && !bitop;

    always_comb begin
        evt          = '0;
        evt.key_ok   = byte_wr && hit_en && (wdata == RESTART_KEY);
        evt.key_bad  = byte_wr && hit_en && (wdata != RESTART_KEY);
        evt.en_bitop = bitop && (wr || rd) && hit_en;
        evt.mode_wr  = byte_wr && hit_mode;
    end

    always_comb begin
        rdata = 8'h00;
        if (rd) begin
            if (hit_en) begin
                rdata = EN_READ_VAL;
            end else if (hit_mode) begin
                rdata = mode_q;
            end
        end
    end

endmodule

// File: rtl/kwdt_ticker.sv
module kwdt_ticker #(
    parameter int BASE_SHIFT = 11,
    parameter int SEL_W      = 3,
    parameter int MAXSEL     = (1 << SEL_W) - 1,
    parameter int CW         = BASE_SHIFT + MAXSEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclr,
    input  logic             clr,
    input  logic             run,
    input  logic             src_ls,
    input  logic             lsclk_en,
    input  logic [SEL_W-1:0] sel,
    output logic [CW-1:0]    cnt,
    output logic             ovf
);

    logic          tick;
    logic [CW-1:0] lim_m1;
    logic [CW-1:0] cnt_q;

    assign tick   = run && (src_ls ? lsclk_en : 1'b1);
    assign lim_m1 = {CW{1'b1}} >> (MAXSEL - int'(sel));
    assign ovf    = tick && !clr && (cnt_q == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sclr || clr || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/kwdt_fsm.sv
module kwdt_fsm
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  kwdt_evt_t   evt,
    input  logic        ovf,
    input  logic [7:0]  wdata,
    output kwdt_state_e st,
    output logic [7:0]  mode_q,
    output logic        rst_req,
    output logic        run,
    output logic        cnt_clr,
    output logic        sclr
);

    kwdt_state_e st_q;
    kwdt_state_e st_d;
    logic        mode_load;
    logic        violation;

    // Protocol violations that matter while the watchdog runs.
    assign violation = evt.key_bad || evt.en_bitop;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OPEN: begin
                if (violation || ovf) begin
                    st_d = ST_FIRE;
                end else if (evt.mode_wr) begin
                    st_d = wdata[STOP_BIT] ? ST_STOP : ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (violation || ovf || evt.mode_wr) begin
                    st_d = ST_FIRE;
                end
            end
            ST_STOP: begin
                st_d = ST_STOP;
            end
            ST_FIRE: begin
                st_d = ST_OPEN;
            end
            default: begin
                st_d = ST_FIRE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        rst_req   = (st_q == ST_FIRE);
        sclr      = (st_q == ST_FIRE);
        run       = (st_q == ST_OPEN) || (st_q == ST_LOCK);
        mode_load = (st_q == ST_OPEN) && evt.mode_wr;
        cnt_clr   = evt.key_ok || mode_load;
    end

    // Setup register, written once per reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST_VAL;
        end else if (st_q == ST_FIRE) begin
            mode_q <= MODE_RST_VAL;
        end else if (mode_load) begin
            mode_q <= wdata;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR  = 16'hFF48,
    parameter logic [ADDR_W-1:0] EN_ADDR    = 16'hFF49,
    parameter int                BASE_SHIFT = 11,
    parameter int                SEL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_bitop,
    input  logic [7:0]        bus_wdata,
    input  logic              lsclk_en,
    output logic [7:0]        bus_rdata,
    output logic              rst_req
);

    localparam int MAXSEL = (1 << SEL_W) - 1;
    localparam int CW     = BASE_SHIFT + MAXSEL;

    kwdt_evt_t     evt;
    kwdt_state_e   st_q;
    logic [7:0]    mode_q;
    logic          run;
    logic          cnt_clr;
    logic          sclr;
    logic          ovf;
    logic [CW-1:0] cnt_q;

    kwdt_busdec #(
        .ADDR_W    (ADDR_W),
        .MODE_ADDR (MODE_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .bitop  (bus_bitop),
        .wdata  (bus_wdata),
        .mode_q (mode_q),
        .evt    (evt),
        .rdata  (bus_rdata)
    );

    kwdt_ticker #(
        .BASE_SHIFT (BASE_SHIFT),
        .SEL_W      (SEL_W),
        .MAXSEL     (MAXSEL),
        .CW         (CW)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclr     (sclr),
        .clr      (cnt_clr),
        .run      (run),
        .src_ls   (mode_q[SRC_BIT]),
        .lsclk_en (lsclk_en),
        .sel      (mode_q[SEL_W-1:0]),
        .cnt      (cnt_q),
        .ovf      (ovf)
    );

    kwdt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .ovf     (ovf),
        .wdata   (bus_wdata),
        .st      (st_q),
        .mode_q  (mode_q),
        .rst_req (rst_req),
        .run     (run),
        .cnt_clr (cnt_clr),
        .sclr    (sclr)
    );

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
    import kwdt_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFF48,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFF49,
    parameter int                CW        = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_bitop,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              rst_req,
    input kwdt_state_e       st,
    input logic [CW-1:0]     cnt
);

    logic live;
    assign live = !rst_req && (st != ST_STOP);

    p_enread_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == EN_ADDR) |-> (bus_rdata == EN_READ_VAL));

    p_keyclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && bus_wr && !bus_bitop && bus_addr == EN_ADDR && bus_wdata == RESTART_KEY)
        |=> (cnt == '0));

    p_badkey_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && bus_wr && !bus_bitop && bus_addr == EN_ADDR && bus_wdata != RESTART_KEY)
        |=> rst_req);

    p_bitop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && bus_bitop && (bus_wr || bus_rd) && bus_addr == EN_ADDR) |=> rst_req);

    p_twice_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && st == ST_LOCK && bus_wr && !bus_bitop && bus_addr == MODE_ADDR)
        |=> rst_req);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |=> (!rst_req && cnt == '0));

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (st == ST_OPEN && cnt == '0));

endmodule

bind kwdt_top kwdt_chk #(
    .ADDR_W    (ADDR_W),
    .MODE_ADDR (MODE_ADDR),
    .EN_ADDR   (EN_ADDR),
    .CW        (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_bitop (bus_bitop),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .st        (st_q),
    .cnt       (cnt_q)
);

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;

    localparam logic [15:0] A_MODE = 16'hFF48;
    localparam logic [15:0] A_EN   = 16'hFF49;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        bitop = 1'b0;
    logic [7:0]  wdata = '0;
    logic        ls = 1'b0;
    logic [7:0]  rdata;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state: 0 open, 1 locked, 2 stopped, 3 firing
    int         m_st = 0;
    int         m_cnt = 0;
    logic [7:0] m_mode = 8'h07;
    bit         m_req = 0;
    int         ls_div = 0;

    always #2.5 clk = ~clk;

    kwdt_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_bitop (bitop),
        .bus_wdata (wdata),
        .lsclk_en  (ls),
        .bus_rdata (rdata),
        .rst_req   (rst_req)
    );

    always @(negedge clk) begin
        ls_div = ls_div + 1;
        ls = ((ls_div % 4) == 0);
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, stepped on every edge and compared shortly after.
    always @(posedge clk) begin
        bit enbit, keyok, keybad, mwr, ld, tick, clr, ovf, fire;
        int lim;
        logic [7:0] exp_rd;
        if (!rst_n || m_st == 3) begin
            m_st = 0; m_cnt = 0; m_mode = 8'h07;
        end else begin
            enbit  = bitop && (wr || rd) && addr == A_EN;
            keyok  = wr && !bitop && addr == A_EN && wdata == 8'hAC;
            keybad = wr && !bitop && addr == A_EN && wdata != 8'hAC;
            mwr    = wr && !bitop && addr == A_MODE;
            ld     = (m_st == 0) && mwr;
            tick   = (m_st != 2) && (m_mode[3] ? ls : 1'b1);
            lim    = 1 << (int'(m_mode[2:0]) + 11);
            clr    = keyok || ld;
            ovf    = tick && !clr && (m_cnt == lim - 1);
            fire   = ovf || ((m_st != 2) && (keybad || enbit)) || ((m_st == 1) && mwr);
            if (clr || m_st == 2) m_cnt = 0;
            else if (tick) m_cnt = m_cnt + 1;
            if (fire) m_st = 3;
            else if (ld) begin
                m_mode = wdata;
                m_st = wdata[4] ? 2 : 1;
            end
        end
        m_req = (m_st == 3);
        #1;
        exp_rd = 8'h00;
        if (rd) exp_rd = (addr == A_EN) ? 8'h9A : ((addr == A_MODE) ? m_mode : 8'h00);
        if (!done) begin
            chk("R9/R10 model rst_req", int'(rst_req), int'(m_req));
            chk("R2/R8 model rdata", int'(rdata), int'(exp_rd));
        end
    end

    task automatic access(input logic [15:0] a, input logic [7:0] d, input bit is_rd, input bit is_bit);
        @(negedge clk);
        addr = a; wdata = d; wr = !is_rd; rd = is_rd; bitop = is_bit;
        @(negedge clk);
        wr = 0; rd = 0; bitop = 0; addr = '0; wdata = '0;
    endtask

    task automatic rd_check(input logic [15:0] a, input logic [7:0] exp, input string tag);
        addr = a; rd = 1;
        #1;
        chk(tag, int'(rdata), int'(exp));
        rd = 0; addr = '0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        wait_n(1);
        // R1 reset state
        chk("R1 rst_req", int'(rst_req), 0);
        rd_check(A_EN, 8'h9A, "R1 restart read");
        rd_check(A_MODE, 8'h07, "R1 setup read");

        // R4 wrong key, then R10 single-cycle request and restore
        access(A_EN, 8'h55, 0, 0);
        chk("R4 wrong key", int'(rst_req), 1);
        wait_n(1);
        chk("R10 pulse ends", int'(rst_req), 0);
        rd_check(A_MODE, 8'h07, "R10 setup restored");
        rd_check(A_EN, 8'h9A, "R2 read after bad write");

        // R5 single-bit accesses to restart register
        access(A_EN, 8'hAC, 0, 1);
        chk("R5 bit write with key", int'(rst_req), 1);
        wait_n(1);
        access(A_EN, 8'h00, 1, 1);
        chk("R5 bit read", int'(rst_req), 1);
        wait_n(1);

        // R7 single-bit write to setup ignored
        access(A_MODE, 8'h10, 0, 1);
        chk("R7 no request", int'(rst_req), 0);
        rd_check(A_MODE, 8'h07, "R7 setup unchanged");

        // R6 first write accepted, then R3 overflow timing at select 0
        access(A_MODE, 8'h00, 0, 0);
        chk("R6 first write ok", int'(rst_req), 0);
        rd_check(A_MODE, 8'h00, "R6 setup value");
        access(A_EN, 8'hAC, 0, 0);
        chk("R3 key accepted", int'(rst_req), 0);
        rd_check(A_EN, 8'h9A, "R2 read after key");
        wait_n(2047);
        chk("R3 no overflow yet", int'(rst_req), 0);
        wait_n(1);
        chk("R9 overflow", int'(rst_req), 1);
        wait_n(1);
        chk("R10 after overflow", int'(rst_req), 0);
        rd_check(A_MODE, 8'h07, "R10 setup restored");

        // R6 second write
        access(A_MODE, 8'h01, 0, 0);
        access(A_MODE, 8'h02, 0, 0);
        chk("R6 second write", int'(rst_req), 1);
        wait_n(1);

        // R3 restart postpones overflow at select 1
        access(A_MODE, 8'h01, 0, 0);
        wait_n(3000);
        access(A_EN, 8'hAC, 0, 0);
        wait_n(3000);
        chk("R3 refresh held off", int'(rst_req), 0);
        wait_n(1095);
        chk("R3 just before overflow", int'(rst_req), 0);
        wait_n(1);
        chk("R9 overflow select 1", int'(rst_req), 1);
        wait_n(1);

        // R11 slow clock source
        access(A_MODE, 8'h08, 0, 0);
        wait_n(4000);
        chk("R11 slow count", int'(rst_req), 0);
        for (int i = 0; i < 10000 && !rst_req; i++) @(negedge clk);
        chk("R11 slow overflow", int'(rst_req), 1);
        wait_n(1);

        // R8 stopped watchdog ignores violations
        access(A_MODE, 8'h10, 0, 0);
        chk("R8 stop accepted", int'(rst_req), 0);
        access(A_EN, 8'h33, 0, 0);
        chk("R8 wrong key ignored", int'(rst_req), 0);
        access(A_EN, 8'hAC, 0, 1);
        chk("R8 bit access ignored", int'(rst_req), 0);
        access(A_MODE, 8'h00, 0, 0);
        chk("R8 second write ignored", int'(rst_req), 0);
        rd_check(A_MODE, 8'h10, "R8 setup kept");
        wait_n(3000);
        chk("R8 no overflow", int'(rst_req), 0);

        // external reset leaves stop
        rst_n = 0;
        wait_n(2);
        rst_n = 1;
        wait_n(1);
        rd_check(A_MODE, 8'h07, "R1 setup after reset");
        chk("R1 rst_req after reset", int'(rst_req), 0);
        wait_n(2);
        finish_run();
    end

endmodule